// File: doc/BRIEF.md
# Posted Store Buffer with Read-Miss Forwarding

This block sits between a data cache and the next memory level and holds stores that have not yet reached memory. The cache side hands over an address/data pair and is released as soon as the pair is taken in. The block then writes the pending stores to memory one after another, oldest first, through a single request channel that it shares with read misses.

A read miss must not go straight past the block. A pending store may hold a newer value for the word the miss asks for, and memory would return stale data. A mode input sets how this is handled. In forwarding mode the requested address is compared against every pending entry. On a match the youngest matching entry answers at once, with no memory access. On no match the read goes to memory ahead of the queued stores. In drain mode the read is held until every pending store has reached memory, and only then is it sent downstream.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty: `cpu_wr_ready` and `rd_req_ready` are 1, and `mem_req_valid` and `rd_rsp_valid` are 0.
- R2: A store is accepted in any cycle where `cpu_wr_valid` and `cpu_wr_ready` are both 1. With 4 stores pending, `cpu_wr_ready` is 0 until one of them drains.
- R3: Pending stores are written to memory strictly in the order they were accepted. Each one is shown on the memory channel with `mem_req_we` = 1 and its own address and data.
- R4: In forwarding mode (`mode_fwd` = 1), a read whose address matches a pending entry raises `rd_rsp_valid` in the cycle after it is accepted. It returns the data of the youngest matching entry and makes no memory read.
- R5: In forwarding mode, a read that matches no entry is sent to memory (`mem_req_we` = 0) in the cycle after it is accepted, ahead of any pending store. Its data is returned on `rd_rsp_valid` in the cycle after `mem_rsp_valid`.
- R6: In drain mode (`mode_fwd` = 0), a read is not sent to memory while any store is pending. `cpu_wr_ready` stays 0 from acceptance until the read has been sent. The read goes out only after all stores ahead of it have drained.
- R7: Only one read is in progress at a time: `rd_req_ready` is 0 from the cycle after a read is accepted until its response is given.
- R8: Every read returns the value of the most recent store to its address that was accepted before the read, or the memory content if there is no such store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_fwd | input | 1 | 1: forward from pending stores; 0: drain before a read |
| cpu_wr_valid | input | 1 | Store offered by the cache |
| cpu_wr_ready | output | 1 | Store can be accepted |
| cpu_wr_addr | input | 32 | Store word address |
| cpu_wr_data | input | 32 | Store data |
| rd_req_valid | input | 1 | Read miss offered |
| rd_req_ready | output | 1 | Read miss can be accepted |
| rd_req_addr | input | 32 | Read miss word address |
| rd_rsp_valid | output | 1 | One-cycle pulse: read data is valid |
| rd_rsp_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_we | output | 1 | 1: write request; 0: read request |
| mem_req_addr | output | 32 | Memory request word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
A broken pointer or a lost valid bit shows on the memory channel at the next drained store: the address or data comes out of order or is repeated. A valid flag left set after its entry drains shows on the next forwarding read to that address. The read answers in one cycle with stale data and no memory read, where a memory read was expected. A fault in the age ordering of the match shows as an older value returned when the same word was stored twice. A fault in drain-mode gating shows as a memory read on the channel while stores are still queued. The bench checks this against a reference copy of memory, together with the cycle each response arrives in.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE      = 2'd0,
    RD_DRAINWAIT = 2'd1,
    RD_ISSUE     = 2'd2,
    RD_WAITRSP   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic [PW-1:0]              head_ptr,
  output logic                       empty,
  output logic                       full,
  output logic [DEPTH-1:0]           ent_vld,
  output logic [DEPTH-1:0][AW-1:0]   ent_addr,
  output logic [DEPTH-1:0][DW-1:0]   ent_data
);
  localparam logic [PW:0] CNT_FULL = (PW+1)'(DEPTH);

  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [PW:0]      cnt_q, cnt_d;
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    vld_d    = vld_q;
    cnt_d    = cnt_q;
    if (pop) begin
      vld_d[rd_ptr_q] = 1'b0;
      rd_ptr_d        = rd_ptr_q + PW'(1);
    end
    if (push) begin
      vld_d[wr_ptr_q] = 1'b1;
      wr_ptr_d        = wr_ptr_q + PW'(1);
    end
    if (push && !pop)
      cnt_d = cnt_q + (PW+1)'(1);
    else if (pop && !push)
      cnt_d = cnt_q - (PW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      vld_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      vld_q    <= vld_d;
    end
  end

  // Payload storage: no reset, written only through its own enable.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_ptr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        addr_q[g] <= push_addr;
        data_q[g] <= push_data;
      end
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign head_ptr  = rd_ptr_q;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_FULL);
  assign ent_vld   = vld_q;
  assign ent_addr  = addr_q;
  assign ent_data  = data_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CNT_FULL));
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (vld_q[rd_ptr_q]));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt_q == $past(cnt_q) - (PW+1)'(1)));
  // R2
  vld_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld_q) == int'(cnt_q)));
endmodule

// File: rtl/wbuf_lookup.sv
module wbuf_lookup #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PW    = 2
) (
  input  logic [AW-1:0]              req_addr,
  input  logic [PW-1:0]              head_ptr,
  input  logic [DEPTH-1:0]           ent_vld,
  input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
  input  logic [DEPTH-1:0][DW-1:0]   ent_data,
  output logic                       hit,
  output logic [DW-1:0]              hit_data
);
  logic [PW-1:0] idx;

  // Walk from oldest to youngest; a later match overrides, so the
  // youngest matching entry wins.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = head_ptr;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_ptr + PW'(k);
      if (ent_vld[idx] && (ent_addr[idx] == req_addr)) begin
        hit      = 1'b1;
        hit_data = ent_data[idx];
      end
    end
  end
endmodule

// File: rtl/wbuf_rd_ctrl.sv
module wbuf_rd_ctrl
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_fwd,
  input  logic          rd_req_valid,
  output logic          rd_req_ready,
  input  logic [AW-1:0] rd_req_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          fifo_empty,
  output logic          mem_rd_valid,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          wr_block,
  output logic          rd_rsp_valid,
  output logic [DW-1:0] rd_rsp_data
);
  rd_state_e     state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          waited_q, waited_d;
  logic          rsp_vld_q, rsp_vld_d;
  logic [DW-1:0] rsp_dat_q, rsp_dat_d;
  logic          accept;
  logic          addr_en, rsp_en;

  assign accept = rd_req_valid && (state_q == RD_IDLE);

  always_comb begin
    state_d   = state_q;
    addr_d    = rd_req_addr;
    addr_en   = 1'b0;
    waited_d  = waited_q;
    rsp_vld_d = 1'b0;
    rsp_dat_d = hit_data;
    rsp_en    = 1'b0;
    unique case (state_q)
      RD_IDLE: begin
        if (accept) begin
          addr_en = 1'b1;
          if (mode_fwd) begin
            waited_d = 1'b0;
            if (hit) begin
              rsp_vld_d = 1'b1;
              rsp_en    = 1'b1;
            end else begin
              state_d = RD_ISSUE;
            end
          end else begin
            waited_d = 1'b1;
            state_d  = RD_DRAINWAIT;
          end
        end
      end
      RD_DRAINWAIT: if (fifo_empty) state_d = RD_ISSUE;
      RD_ISSUE:     if (mem_req_ready) state_d = RD_WAITRSP;
      RD_WAITRSP: begin
        if (mem_rsp_valid) begin
          state_d   = RD_IDLE;
          waited_d  = 1'b0;
          rsp_vld_d = 1'b1;
          rsp_dat_d = mem_rsp_data;
          rsp_en    = 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RD_IDLE;
      waited_q  <= 1'b0;
      rsp_vld_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      waited_q  <= waited_d;
      rsp_vld_q <= rsp_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q    <= addr_d;
    if (rsp_en)  rsp_dat_q <= rsp_dat_d;
  end

  assign rd_req_ready = (state_q == RD_IDLE);
  assign mem_rd_valid = (state_q == RD_ISSUE);
  assign mem_rd_addr  = addr_q;
  assign wr_block     = waited_q &&
                        ((state_q == RD_DRAINWAIT) || (state_q == RD_ISSUE));
  assign rd_rsp_valid = rsp_vld_q;
  assign rd_rsp_data  = rsp_dat_q;

  // R4
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_fwd && hit) |=> (rd_rsp_valid && !mem_rd_valid));
  // R5
  miss_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_fwd && !hit) |=> (mem_rd_valid && !rd_rsp_valid));
  // R6
  wait_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && waited_q) |-> fifo_empty);
  // R7
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(mode_fwd && hit)) |=> !rd_req_ready);
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_fwd,
  input  logic          cpu_wr_valid,
  output logic          cpu_wr_ready,
  input  logic [AW-1:0] cpu_wr_addr,
  input  logic [DW-1:0] cpu_wr_data,
  input  logic          rd_req_valid,
  output logic          rd_req_ready,
  input  logic [AW-1:0] rd_req_addr,
  output logic          rd_rsp_valid,
  output logic [DW-1:0] rd_rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                     push, pop;
  logic                     empty, full;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [PTR_W-1:0]         head_ptr;
  logic [DEPTH-1:0]         ent_vld;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic                     hit;
  logic [DW-1:0]            hit_data;
  logic                     mem_rd_valid;
  logic [AW-1:0]            mem_rd_addr;
  logic                     wr_block;
  logic                     drain_valid;

  assign cpu_wr_ready = !full && !wr_block;
  assign push         = cpu_wr_valid && cpu_wr_ready;
  // A pending read owns the memory channel; stores drain otherwise.
  assign drain_valid  = !empty && !mem_rd_valid;
  assign pop          = drain_valid && mem_req_ready;

  assign mem_req_valid = mem_rd_valid || drain_valid;
  assign mem_req_we    = !mem_rd_valid;
  assign mem_req_addr  = mem_rd_valid ? mem_rd_addr : head_addr;
  assign mem_req_wdata = head_data;

  wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PTR_W)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (cpu_wr_addr),
    .push_data (cpu_wr_data),
    .pop       (pop),
    .head_addr (head_addr),
    .head_data (head_data),
    .head_ptr  (head_ptr),
    .empty     (empty),
    .full      (full),
    .ent_vld   (ent_vld),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data)
  );

  wbuf_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PTR_W)) lookup_i (
    .req_addr (rd_req_addr),
    .head_ptr (head_ptr),
    .ent_vld  (ent_vld),
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .hit      (hit),
    .hit_data (hit_data)
  );

  wbuf_rd_ctrl #(.AW(AW), .DW(DW)) rdctl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_fwd      (mode_fwd),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_addr   (rd_req_addr),
    .hit           (hit),
    .hit_data      (hit_data),
    .fifo_empty    (empty),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .wr_block      (wr_block),
    .rd_rsp_valid  (rd_rsp_valid),
    .rd_rsp_data   (rd_rsp_data)
  );

  // R5
  read_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_req_ready) |-> !pop);
  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && !mem_req_ready && !rd_req_valid)
      |=> (mem_req_valid && mem_req_we && $stable(mem_req_addr)));
endmodule

// File: tb/wbuf_top_tb_top.sv
module wbuf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_fwd;
  logic        cpu_wr_valid;
  logic        cpu_wr_ready;
  logic [31:0] cpu_wr_addr;
  logic [31:0] cpu_wr_data;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        mem_req_valid;
  logic        mem_rdy;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #5 clk = ~clk;

  wbuf_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_fwd(mode_fwd),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_rdy), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Memory model, reference copy and channel monitor
  logic [31:0] mem_arr [64];
  logic [31:0] ref_mem [64];
  logic [31:0] drain_log [256];
  int          drain_cnt;
  int          rd_cnt;
  int          rd_at_drain;
  int          vectors;
  int          miscompares;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      drain_cnt     <= 0;
      rd_cnt        <= 0;
      rd_at_drain   <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_rdy) begin
        if (mem_req_we) begin
          mem_arr[mem_req_addr[5:0]] <= mem_req_wdata;
          drain_log[drain_cnt[7:0]]  <= mem_req_addr;
          drain_cnt                  <= drain_cnt + 1;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem_arr[mem_req_addr[5:0]];
          rd_cnt        <= rd_cnt + 1;
          rd_at_drain   <= drain_cnt;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    int n = 0;
    cpu_wr_valid = 1'b1;
    cpu_wr_addr  = a;
    cpu_wr_data  = d;
    while (!cpu_wr_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    cpu_wr_valid = 1'b0;
    ref_mem[a[5:0]] = d;
  endtask

  task automatic do_read(input logic [31:0] a, input bit rel_rdy,
                         output logic [31:0] data, output int lat,
                         output bit rdy_after);
    int n = 0;
    while (!rd_req_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    rd_req_valid = 1'b1;
    rd_req_addr  = a;
    @(negedge clk);
    rd_req_valid = 1'b0;
    rdy_after    = rd_req_ready;
    if (rel_rdy) mem_rdy = 1'b1;
    lat = 0;
    while (!rd_rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    data = rd_rsp_data;
    @(negedge clk);
  endtask

  task automatic wait_drained();
    int n = 0;
    mem_rdy = 1'b1;
    while (mem_req_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk(cpu_wr_ready == 1'b1, "R1 cpu_wr_ready", 32'(cpu_wr_ready), 32'd1);
    chk(rd_req_ready == 1'b1, "R1 rd_req_ready", 32'(rd_req_ready), 32'd1);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk(rd_rsp_valid == 1'b0, "R1 rd_rsp_valid", 32'(rd_rsp_valid), 32'd0);
  endtask

  task automatic t_fill_order();
    int base;
    mem_rdy  = 1'b0;
    base     = drain_cnt;
    for (int i = 0; i < 4; i++) do_write(32'(i + 1), 32'hA500 + 32'(i));
    chk(cpu_wr_ready == 1'b0, "R2 full ready", 32'(cpu_wr_ready), 32'd0);
    chk(mem_req_valid && mem_req_we && mem_req_addr == 32'd1,
        "R3 head shown", mem_req_addr, 32'd1);
    wait_drained();
    chk(drain_cnt == base + 4, "R3 drain count", 32'(drain_cnt), 32'(base + 4));
    for (int i = 0; i < 4; i++)
      chk(drain_log[base + i] == 32'(i + 1), "R3 drain order",
          drain_log[base + i], 32'(i + 1));
    chk(mem_arr[3] == 32'hA502, "R3 drained data", mem_arr[3], 32'hA502);
    chk(cpu_wr_ready == 1'b1, "R2 ready after drain", 32'(cpu_wr_ready), 32'd1);
  endtask

  task automatic t_fwd_youngest();
    logic [31:0] d;
    int lat, rd0;
    bit ra;
    mode_fwd = 1'b1;
    mem_rdy  = 1'b0;
    do_write(32'd10, 32'h111);
    do_write(32'd11, 32'h222);
    do_write(32'd10, 32'h333);
    rd0 = rd_cnt;
    do_read(32'd10, 1'b0, d, lat, ra);
    chk(d == 32'h333, "R4 youngest data", d, 32'h333);
    chk(lat == 0, "R4 hit latency", 32'(lat), 32'd0);
    do_read(32'd11, 1'b0, d, lat, ra);
    chk(d == ref_mem[11], "R8 fwd other", d, ref_mem[11]);
    chk(rd_cnt == rd0, "R4 no mem read", 32'(rd_cnt), 32'(rd0));
    wait_drained();
  endtask

  task automatic t_fwd_miss();
    logic [31:0] d;
    int lat, dr0;
    bit ra;
    mode_fwd = 1'b1;
    mem_rdy  = 1'b0;
    do_write(32'd20, 32'h2020);
    do_write(32'd21, 32'h2121);
    dr0 = drain_cnt;
    do_read(32'd30, 1'b1, d, lat, ra);
    chk(ra == 1'b0, "R7 busy after accept", 32'(ra), 32'd0);
    chk(d == ref_mem[30], "R5 miss data", d, ref_mem[30]);
    chk(rd_at_drain == dr0, "R5 read before drains", 32'(rd_at_drain), 32'(dr0));
    chk(lat == 2, "R5 miss latency", 32'(lat), 32'd2);
    wait_drained();
  endtask

  task automatic t_wait_mode();
    logic [31:0] d;
    int lat, rd0, dr0;
    mode_fwd = 1'b0;
    mem_rdy  = 1'b0;
    do_write(32'd40, 32'h4444);
    do_write(32'd41, 32'h4141);
    rd0 = rd_cnt;
    dr0 = drain_cnt;
    rd_req_valid = 1'b1;
    rd_req_addr  = 32'd40;
    @(negedge clk);
    rd_req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_cnt == rd0, "R6 no early read", 32'(rd_cnt), 32'(rd0));
    chk(cpu_wr_ready == 1'b0, "R6 writes held", 32'(cpu_wr_ready), 32'd0);
    chk(rd_req_ready == 1'b0, "R7 busy while waiting", 32'(rd_req_ready), 32'd0);
    mem_rdy = 1'b1;
    lat = 0;
    while (!rd_rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    d = rd_rsp_data;
    @(negedge clk);
    chk(d == 32'h4444, "R8 wait-mode data", d, 32'h4444);
    chk(rd_at_drain == dr0 + 2, "R6 read after drain", 32'(rd_at_drain), 32'(dr0 + 2));
    chk(cpu_wr_ready == 1'b1, "R6 writes resume", 32'(cpu_wr_ready), 32'd1);
  endtask

  task automatic t_mixed();
    logic [31:0] d;
    int lat;
    bit ra;
    for (int i = 0; i < 24; i++) begin
      mem_rdy  = i[0];
      do_write(32'(48 + (i % 8)), 32'h5A00_0000 + 32'(i * 7));
      if ((i % 3) == 2) begin
        logic [31:0] a;
        a = 32'(48 + ((i * 5) % 8));
        mode_fwd = i[2];
        mem_rdy  = 1'b1;
        do_read(a, 1'b0, d, lat, ra);
        chk(d == ref_mem[a[5:0]], "R8 mixed read", d, ref_mem[a[5:0]]);
      end
    end
    wait_drained();
    for (int j = 48; j < 56; j++)
      chk(mem_arr[j] == ref_mem[j], "R3 final memory", mem_arr[j], ref_mem[j]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=%0d exp=%0d", 50000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    vectors      = 0;
    miscompares  = 0;
    for (int i = 0; i < 64; i++) begin
      mem_arr[i] = 32'hC0DE_0000 | 32'(i);
      ref_mem[i] = 32'hC0DE_0000 | 32'(i);
    end
    rst_n        = 1'b0;
    mode_fwd     = 1'b1;
    cpu_wr_valid = 1'b0;
    cpu_wr_addr  = '0;
    cpu_wr_data  = '0;
    rd_req_valid = 1'b0;
    rd_req_addr  = '0;
    mem_rdy      = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_order();
    t_fwd_youngest();
    t_fwd_miss();
    t_wait_mode();
    t_mixed();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule